// File: doc/BRIEF.md
# Dithered Phase Accumulator

This block is the phase generator at the front of a direct digital synthesizer. A wide accumulator adds a frequency tuning word on every sample clock. Before the accumulated phase is cut down to the narrow address that feeds the sine lookup, a small pseudorandom word is added below the cut point. Truncation then rounds up or down at random instead of always in the same pattern. The periodic error that truncation would otherwise cause is turned into broadband noise, and the discrete spurs at the synthesizer output become weaker.

The random word comes from an internal linear-feedback shift register. A shift control sets how far up the discarded bits the random word is placed, and so how strong the dither is. The shift is clamped so the random word can never reach the retained phase bits. Dither can be turned off. The block then gives the plain truncated phase. The output is registered and carries a valid strobe.

Top module: `dithered_phase_path`

## Requirements
- R1: While `rst` is high at a clock edge, the registers after that edge hold `phase_out` = 0 and `phase_valid` = 0.
- R2: After `rst` is released, `phase_valid` stays 0 after the first rising edge, becomes 1 after the second, and then stays 1 until the next reset.
- R3: The accumulator starts at 0 at reset and adds `tune_word` modulo 2^32 on every edge after reset. The value of `tune_word` present at an edge is the one added at that edge.
- R4: `phase_out` after an edge is built from the accumulator value held before that edge, so the output lags the accumulator update by one cycle. It is bits [31:18] of that value, plus the dither word, taken modulo 2^32.
- R5: The dither word is the 4 low bits of a 15-bit LFSR with feedback polynomial x^15+x^14+1 (new bit = bit14 XOR bit13, shifted in at bit 0), shifted left by the effective shift. The LFSR starts from a nonzero seed at reset and advances on every edge after reset.
- R6: The effective shift is `dither_shift`, saturated to 14 (that is, T-A-R). The dither word therefore never has a bit at position 18 or above. If the low 18 accumulator bits plus (15 << effective shift) are below 2^18, the output equals the plain truncation for any shift request, including requests above 14.
- R7: With `dither_en` = 0, the dither word is 0 and `phase_out` equals the plain truncation of the accumulator.
- R8: With `dither_en` = 1, `phase_out` equals either the plain truncation or the plain truncation plus 1 (modulo 2^14). With a shift of 14 and a tuning word whose low bits vary, both outcomes occur.
- R9: The LFSR state is never zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| tune_word | input | 32 | Frequency tuning word added each cycle |
| dither_en | input | 1 | Enables injection of the random word |
| dither_shift | input | 5 | Requested left shift of the random word (saturated to 14) |
| phase_out | output | 14 | Truncated, dithered phase address |
| phase_valid | output | 1 | High once the output reflects an accumulated phase |

## Verification
The assertions assume that reset is held for at least one edge before use and that `rst` is driven to a known level from time zero. They do not assume anything about `dither_shift`: the clamp must hold for every 5-bit value, and the stimulus deliberately requests shifts of 15 and 31. The bench changes `tune_word`, `dither_en` and `dither_shift` only at falling edges, so each rising edge sees one stable set of inputs. It tracks the accumulator itself from the tuning words it applied. Where dither is enabled, it checks that the output falls within the bounds that the clamped dither magnitude allows.

// File: rtl/dphase_pkg.sv
package dphase_pkg;
  // Saturating clamp for the dither placement request.
  function automatic int unsigned sat_shift(int unsigned req, int unsigned lim);
    return (req > lim) ? lim : req;
  endfunction
endpackage

// File: rtl/dphase_prbs.sv
module dphase_prbs #(
  parameter int          LFSR_W = 15,
  parameter int          TAP_HI = 14,
  parameter int          TAP_LO = 13,
  parameter int          RND_W  = 4,
  parameter logic [14:0] SEED   = 15'h2B5D
) (
  input  logic              clk,
  input  logic              rst,
  output logic [LFSR_W-1:0] state_q,
  output logic [RND_W-1:0]  rnd
);
  logic fb;

  // Fibonacci feedback from the two highest taps.
  assign fb = state_q[TAP_HI] ^ state_q[TAP_LO];

  always_ff @(posedge clk) begin
    if (rst) state_q <= SEED[LFSR_W-1:0];
    else     state_q <= {state_q[LFSR_W-2:0], fb};
  end

  assign rnd = state_q[RND_W-1:0];
endmodule

// File: rtl/dphase_acc.sv
module dphase_acc #(
  parameter int PHASE_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PHASE_W-1:0] tune_word,
  output logic [PHASE_W-1:0] acc_q,
  output logic               upd_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      upd_q <= 1'b0;
    end else begin
      acc_q <= acc_q + tune_word;
      upd_q <= 1'b1;
    end
  end
endmodule

// File: rtl/dphase_place.sv
module dphase_place #(
  parameter int PHASE_W = 32,
  parameter int ADDR_W  = 14,
  parameter int RND_W   = 4,
  parameter int SHIFT_W = 5
) (
  input  logic [RND_W-1:0]   rnd,
  input  logic               en,
  input  logic [SHIFT_W-1:0] shift_req,
  output logic [PHASE_W-1:0] word
);
  import dphase_pkg::*;

  localparam int MAX_SH = PHASE_W - ADDR_W - RND_W;
  localparam int SEL_W  = (MAX_SH > 0) ? $clog2(MAX_SH + 1) : 1;

  logic [PHASE_W-1:0] cand [MAX_SH+1];
  logic [SEL_W-1:0]   sel;

  // One candidate per legal placement; the top one puts the random MSB
  // one bit below the retained phase.
  for (genvar s = 0; s <= MAX_SH; s++) begin : g_pos
    assign cand[s] = {{(PHASE_W-RND_W){1'b0}}, rnd} << s;
  end

  always_comb begin
    sel = SEL_W'(sat_shift(int'(shift_req), MAX_SH));
    word = en ? cand[sel] : '0;
  end
endmodule

// File: rtl/dphase_trunc.sv
module dphase_trunc #(
  parameter int PHASE_W = 32,
  parameter int ADDR_W  = 14
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PHASE_W-1:0] acc,
  input  logic [PHASE_W-1:0] dither,
  input  logic               acc_upd,
  output logic [ADDR_W-1:0]  phase_out,
  output logic               phase_valid
);
  logic [PHASE_W-1:0] sum;
  logic               unused_low;

  assign sum        = acc + dither;
  assign unused_low = ^sum[PHASE_W-ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_out   <= '0;
      phase_valid <= 1'b0;
    end else begin
      phase_out   <= sum[PHASE_W-1:PHASE_W-ADDR_W];
      phase_valid <= acc_upd;
    end
  end
endmodule

// File: rtl/dithered_phase_path.sv
module dithered_phase_path #(
  parameter int PHASE_W = 32,
  parameter int ADDR_W  = 14,
  parameter int RND_W   = 4,
  parameter int LFSR_W  = 15,
  parameter int SHIFT_W = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PHASE_W-1:0] tune_word,
  input  logic               dither_en,
  input  logic [SHIFT_W-1:0] dither_shift,
  output logic [ADDR_W-1:0]  phase_out,
  output logic               phase_valid
);
  logic [PHASE_W-1:0] acc_q;
  logic               upd_q;
  logic [LFSR_W-1:0]  lfsr_q;
  logic [RND_W-1:0]   rnd_w;
  logic [PHASE_W-1:0] dith_w;

  dphase_acc #(.PHASE_W(PHASE_W)) acc_i (
    .clk(clk), .rst(rst), .tune_word(tune_word), .acc_q(acc_q), .upd_q(upd_q)
  );

  dphase_prbs #(.LFSR_W(LFSR_W), .TAP_HI(LFSR_W-1), .TAP_LO(LFSR_W-2), .RND_W(RND_W)) prbs_i (
    .clk(clk), .rst(rst), .state_q(lfsr_q), .rnd(rnd_w)
  );

  dphase_place #(.PHASE_W(PHASE_W), .ADDR_W(ADDR_W), .RND_W(RND_W), .SHIFT_W(SHIFT_W)) place_i (
    .rnd(rnd_w), .en(dither_en), .shift_req(dither_shift), .word(dith_w)
  );

  dphase_trunc #(.PHASE_W(PHASE_W), .ADDR_W(ADDR_W)) trunc_i (
    .clk(clk), .rst(rst), .acc(acc_q), .dither(dith_w), .acc_upd(upd_q),
    .phase_out(phase_out), .phase_valid(phase_valid)
  );
endmodule

// File: rtl/dithered_phase_path_chk.sv
module dithered_phase_path_chk #(
  parameter int PHASE_W = 32,
  parameter int ADDR_W  = 14,
  parameter int LFSR_W  = 15
) (
  input logic               clk,
  input logic               rst,
  input logic               dither_en,
  input logic [LFSR_W-1:0]  lfsr_state,
  input logic [PHASE_W-1:0] dither_word,
  input logic [ADDR_W-1:0]  phase_out,
  input logic               phase_valid
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!phase_valid && phase_out == '0));

  assert_valid_sticky_R2: assert property (@(posedge clk) disable iff (rst)
    phase_valid |=> phase_valid);

  assert_lfsr_advance_R5: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (lfsr_state != $past(lfsr_state)));

  assert_no_overlap_R6: assert property (@(posedge clk) disable iff (rst)
    dither_word[PHASE_W-1:PHASE_W-ADDR_W] == '0);

  assert_dither_off_R7: assert property (@(posedge clk) disable iff (rst)
    !dither_en |-> (dither_word == '0));

  assert_lfsr_nonzero_R9: assert property (@(posedge clk) disable iff (rst)
    lfsr_state != '0);
endmodule

bind dithered_phase_path dithered_phase_path_chk #(
  .PHASE_W(PHASE_W), .ADDR_W(ADDR_W), .LFSR_W(LFSR_W)
) chk_i (
  .clk(clk), .rst(rst), .dither_en(dither_en), .lfsr_state(lfsr_q),
  .dither_word(dith_w), .phase_out(phase_out), .phase_valid(phase_valid)
);

// File: tb/dithered_phase_path_tb_top.sv
`timescale 1ns/1ps
module dithered_phase_path_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] tune_word = '0;
  logic        dither_en = 1'b0;
  logic [4:0]  dither_shift = '0;
  logic [13:0] phase_out;
  logic        phase_valid;

  int total = 0;
  int bad   = 0;
  logic [31:0] model_acc;
  int          n_upd;
  int          carries;

  always #2.5 clk = ~clk;

  dithered_phase_path dut_i (
    .clk(clk), .rst(rst), .tune_word(tune_word), .dither_en(dither_en),
    .dither_shift(dither_shift), .phase_out(phase_out), .phase_valid(phase_valid)
  );

  localparam int NV = 8;
  localparam logic [31:0] V_TW [NV] = '{32'h0001_0000, 32'h1234_5678, 32'hFFFF_FFFF,
                                        32'h0004_0001, 32'h0123_4567, 32'h7FFF_0003,
                                        32'h8000_0000, 32'h0000_3FFF};
  localparam logic        V_EN [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1};
  localparam int          V_SH [NV] = '{0, 0, 14, 0, 31, 9, 7, 14};
  localparam int          V_N  [NV] = '{20, 24, 16, 20, 30, 12, 10, 40};

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(phase_out == '0, "R1", 32'(phase_out), 0);
    check(phase_valid == 1'b0, "R1", 32'(phase_valid), 0);
    rst = 1'b0;
    model_acc = '0;
    n_upd = 0;
  endtask

  // One rising edge; the checks use the inputs and model state that edge saw.
  task automatic step(output bit diff);
    logic [31:0] pre;
    int          pre_n;
    logic        en;
    int          sh, eff;
    logic [13:0] plain;
    logic [18:0] lim;
    @(posedge clk);
    pre = model_acc; pre_n = n_upd; en = dither_en; sh = int'(dither_shift);
    model_acc = model_acc + tune_word;
    n_upd++;
    @(negedge clk);
    diff = 1'b0;
    check(phase_valid == (pre_n >= 1), "R2", 32'(phase_valid), 32'(pre_n >= 1));
    if (pre_n >= 1) begin
      plain = pre[31:18];
      eff = (sh > 14) ? 14 : sh;
      lim = {1'b0, pre[17:0]} + (19'd15 << eff);
      if (!en) begin
        check(phase_out == plain, "R3 R4 R7", 32'(phase_out), 32'(plain));
      end else begin
        diff = (phase_out != plain);
        check(phase_out == plain || (phase_out == plain + 14'd1 && lim[18]),
              "R6 R8", 32'(phase_out), 32'(plain));
      end
    end
  endtask

  initial begin : watchdog
    #(5ns * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit d;
    do_reset();
    // Table walk: accumulation, wrap, dither bounds (R3 R4 R8).
    for (int v = 0; v < NV; v++) begin
      tune_word = V_TW[v]; dither_en = V_EN[v]; dither_shift = 5'(V_SH[v]);
      for (int c = 0; c < V_N[v]; c++) step(d);
    end

    // R6: low accumulator bits stay zero, so even over-range shifts must not move the output.
    foreach (V_SH[k]) begin end
    for (int s = 13; s < 32; s += 1) begin
      if (s != 13 && s != 14 && s != 15 && s != 31) continue;
      do_reset();
      tune_word = 32'h0004_0000; dither_en = 1'b1; dither_shift = 5'(s);
      carries = 0;
      for (int c = 0; c < 30; c++) begin
        step(d);
        if (d) carries++;
      end
      check(carries == 0, "R6 clamp", 32'(carries), 0);
    end

    // R8: at full strength with varying low bits, rounding up must occur.
    do_reset();
    tune_word = 32'h0001_2345; dither_en = 1'b1; dither_shift = 5'd14;
    carries = 0;
    for (int c = 0; c < 200; c++) begin
      step(d);
      if (d) carries++;
    end
    check(carries > 0, "R8 dither active", 32'(carries), 1);
    check(carries < 198, "R8 dither not constant", 32'(carries), 0);

    // R5: the random sequence keeps changing; with shift 0 and low bits near the top,
    // varying random values give a mix of outcomes over time.
    do_reset();
    tune_word = 32'h0003_FFF8; dither_en = 1'b1; dither_shift = 5'd0;
    carries = 0;
    for (int c = 0; c < 120; c++) begin
      step(d);
      if (d) carries++;
    end
    check(carries > 0, "R5 random word nonzero", 32'(carries), 1);

    // R2: valid timing right after a reset in the middle of activity.
    do_reset();
    tune_word = 32'h0100_0000; dither_en = 1'b0;
    step(d);
    step(d);
    check(phase_out == 14'h0040, "R3 second output", 32'(phase_out), 32'h40);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule